// File: doc/BRIEF.md
# Legacy Interrupt Status and Enable Aggregator

This block gathers the four legacy PCIe wire interrupts (INTA, INTB, INTC, INTD) and a small set of miscellaneous event sources into one sticky status word. Each status bit has a matching enable bit. A single interrupt line goes high whenever any bit is both pending and enabled. Software finds the cause by reading the status word, and it acknowledges a cause by writing a one to that bit. It masks or unmasks one line at a time with a read-modify-write of the enable word.

The legacy lines are level sources. The miscellaneous sources are pulse sources: by default they are captured on a rising edge, so an event that stays high is recorded only once. If a source is active in the same cycle as a clear, the source wins. A pending bit stays recorded while it is disabled, and it raises the interrupt as soon as it is enabled.

A third register reads back the controller's link-training state. It also gives a flag that is set when that state is the fully-trained code. All access goes through a flat register port: writes take effect on the clock edge, and reads are combinational from the current address.

Top module: `intx_irq_agg`

## Requirements
- R1: After a synchronous reset, the status word and the enable word read zero and `irq` is low.
- R2: Status and enable share one layout. Miscellaneous source k sits at bit k (bits 0 to 4). INTA, INTB, INTC and INTD sit at bits 5, 6, 7 and 8 (mask 0x1E0). Bits 9 to 31 of both registers read zero.
- R3: A legacy line that is high at a clock edge sets its status bit at that edge. The bit stays set after the line falls, until it is cleared.
- R4: A miscellaneous source sets its status bit only on a low-to-high change. A source held high does not set the bit again after it has been cleared.
- R5: A write to the status register (address 0x0B1C) clears each bit whose write-data bit is one. Bits written with zero, and write-data bits 9 to 31, have no effect.
- R6: If a source sets a bit in the same cycle that a write clears it, the bit ends up set.
- R7: A write to the enable register (address 0x0B0C) loads bits 0 to 8 of the write data. Write-data bits 9 to 31 are dropped. A read returns the stored value.
- R8: `irq` is high exactly when some bit is set in both status and enable. A bit that was latched while disabled raises `irq` when its enable bit is later set.
- R9: A read-modify-write that clears or sets one enable bit leaves the other enable bits and all status bits unchanged. `irq` then follows only the remaining enabled, pending bits.
- R10: The link register (address 0x0404) returns in bits 5:0 the value of `link_state` sampled at the previous clock edge. Bit 8 is one exactly when that sampled value equals 0x2D. All other bits read zero.
- R11: Reads of any other address return zero. Writes to any other address, or to the link register, change neither status nor enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| misc_src | input | 5 | Miscellaneous pulse sources, bit k maps to status bit k |
| intx_in | input | 4 | Legacy level lines, bit 0 is INTA |
| link_state | input | 6 | Link-training state code from the controller |
| csr_addr | input | 16 | Register byte address |
| csr_wr | input | 1 | Write strobe, acted on at the clock edge |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for `csr_addr`, combinational |
| irq | output | 1 | Combined interrupt: any enabled bit pending |

## Verification
The bench builds the block with its default parameters: five miscellaneous edge-captured sources below the four level-captured legacy lines, which gives a nine-bit status word. At this width every one of the 512 status patterns can be set and read back, each paired with an enable value, and every one of the 512 enable words can be tried against a fixed pending pattern. The six-bit link state is also small enough to sweep all 64 codes. Directed sequences cover the cases the sweeps cannot reach: a set that collides with a clear, a held edge source after it has been acknowledged, a single-bit mask change, and writes to the link register and to unmapped addresses.

// File: rtl/intx_irq_pkg.sv
package intx_irq_pkg;

    localparam int DATA_W      = 32;
    localparam int LINK_W      = 6;
    localparam int LINK_UP_BIT = 8;
    localparam logic [LINK_W-1:0] LINK_TRAINED = 6'h2D;

    typedef struct packed {
        logic stat;
        logic en;
        logic link;
    } csr_hit_t;

    typedef struct packed {
        logic wr_stat;
        logic wr_en;
    } csr_wr_t;

    function automatic logic link_is_trained(input logic [LINK_W-1:0] code);
        return code == LINK_TRAINED;
    endfunction

endpackage

// File: rtl/irq_status_bit.sv
module irq_status_bit #(
    parameter bit EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic src_in,
    input  logic clr,
    output logic stat
);
    logic set_now;
    logic stat_q;

    generate
        if (EDGE) begin : g_edge
            logic prev_q;
            always_ff @(posedge clk) begin
                if (rst) prev_q <= 1'b0;
                else     prev_q <= src_in;
            end
            assign set_now = src_in & ~prev_q;

            p_edge_set_r4: assert property (@(posedge clk) disable iff (rst)
                (src_in && !prev_q) |=> stat_q);
            p_held_no_reset_r4: assert property (@(posedge clk) disable iff (rst)
                (prev_q && clr) |=> !stat_q);
        end else begin : g_level
            assign set_now = src_in;

            p_level_set_r3: assert property (@(posedge clk) disable iff (rst)
                src_in |=> stat_q);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) stat_q <= 1'b0;
        else     stat_q <= set_now | (stat_q & ~clr);
    end

    assign stat = stat_q;

    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (stat_q && !clr) |=> stat_q);
    p_w1c_r5: assert property (@(posedge clk) disable iff (rst)
        (clr && !src_in) |=> !stat_q);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        (!src_in && !stat_q) |=> !stat_q);
    p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (clr && set_now) |=> stat_q);

endmodule

// File: rtl/irq_link_mon.sv
module irq_link_mon
    import intx_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LINK_W-1:0] link_state,
    output logic [DATA_W-1:0] link_word
);
    logic [LINK_W-1:0] state_q;
    logic              up;

    always_ff @(posedge clk) begin
        state_q <= link_state;
    end

    assign up = link_is_trained(state_q);

    always_comb begin
        link_word              = '0;
        link_word[LINK_W-1:0]  = state_q;
        link_word[LINK_UP_BIT] = up;
    end

    p_link_flag_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(link_state) == LINK_TRAINED) |-> link_word[LINK_UP_BIT]);
    p_link_code_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> link_word[LINK_W-1:0] == $past(link_state));

endmodule

// File: rtl/irq_csr_decode.sv
module irq_csr_decode
    import intx_irq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h0B1C,
    parameter logic [ADDR_W-1:0] EN_ADDR   = 16'h0B0C,
    parameter logic [ADDR_W-1:0] LINK_ADDR = 16'h0404
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output csr_hit_t          hit,
    output csr_wr_t           wsel
);
    always_comb begin
        hit.stat = (addr == STAT_ADDR);
        hit.en   = (addr == EN_ADDR);
        hit.link = (addr == LINK_ADDR);
        wsel.wr_stat = wr & hit.stat;
        wsel.wr_en   = wr & hit.en;
    end

    p_one_hit_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hit.stat, hit.en, hit.link}));
    p_write_needs_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        !wr |-> (wsel == '0));

endmodule

// File: rtl/intx_irq_agg.sv
module intx_irq_agg
    import intx_irq_pkg::*;
#(
    parameter int NUM_MISC  = 5,
    parameter int NUM_INTX  = 4,
    parameter bit MISC_EDGE = 1'b1,
    parameter int ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h0B1C,
    parameter logic [ADDR_W-1:0] EN_ADDR   = 16'h0B0C,
    parameter logic [ADDR_W-1:0] LINK_ADDR = 16'h0404
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_MISC-1:0] misc_src,
    input  logic [NUM_INTX-1:0] intx_in,
    input  logic [LINK_W-1:0]   link_state,
    input  logic [ADDR_W-1:0]   csr_addr,
    input  logic                csr_wr,
    input  logic [DATA_W-1:0]   csr_wdata,
    output logic [DATA_W-1:0]   csr_rdata,
    output logic                irq
);
    localparam int SRC_W = NUM_MISC + NUM_INTX;

    csr_hit_t          hit;
    csr_wr_t           wsel;
    logic [SRC_W-1:0]  src_all;
    logic [SRC_W-1:0]  clr_vec;
    logic [SRC_W-1:0]  stat_vec;
    logic [SRC_W-1:0]  en_q;
    logic [DATA_W-1:0] link_word;

    irq_csr_decode #(
        .ADDR_W   (ADDR_W),
        .STAT_ADDR(STAT_ADDR),
        .EN_ADDR  (EN_ADDR),
        .LINK_ADDR(LINK_ADDR)
    ) u_dec (
        .clk (clk),
        .rst (rst),
        .addr(csr_addr),
        .wr  (csr_wr),
        .hit (hit),
        .wsel(wsel)
    );

    assign src_all = {intx_in, misc_src};
    assign clr_vec = wsel.wr_stat ? csr_wdata[SRC_W-1:0] : '0;

    for (genvar i = 0; i < SRC_W; i++) begin : g_bit
        irq_status_bit #(
            .EDGE((i < NUM_MISC) ? MISC_EDGE : 1'b0)
        ) u_bit (
            .clk   (clk),
            .rst   (rst),
            .src_in(src_all[i]),
            .clr   (clr_vec[i]),
            .stat  (stat_vec[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)              en_q <= '0;
        else if (wsel.wr_en)  en_q <= csr_wdata[SRC_W-1:0];
    end

    irq_link_mon u_link (
        .clk       (clk),
        .rst       (rst),
        .link_state(link_state),
        .link_word (link_word)
    );

    always_comb begin
        csr_rdata = '0;
        if (hit.stat)      csr_rdata[SRC_W-1:0] = stat_vec;
        else if (hit.en)   csr_rdata[SRC_W-1:0] = en_q;
        else if (hit.link) csr_rdata = link_word;
    end

    assign irq = |(stat_vec & en_q);

    p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (en_q != '0));
    p_irq_needs_pending_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat_vec != '0));
    p_en_load_r7: assert property (@(posedge clk) disable iff (rst)
        wsel.wr_en |=> en_q == $past(csr_wdata[SRC_W-1:0]));
    p_en_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !wsel.wr_en |=> $stable(en_q));

endmodule

// File: tb/tb_intx_irq_agg.sv
module tb_intx_irq_agg;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] A_STAT = 16'h0B1C;
    localparam logic [15:0] A_EN   = 16'h0B0C;
    localparam logic [15:0] A_LINK = 16'h0404;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  misc_src = '0;
    logic [3:0]  intx_in = '0;
    logic [5:0]  link_state = '0;
    logic [15:0] csr_addr = '0;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    intx_irq_agg dut (
        .clk(clk), .rst(rst), .misc_src(misc_src), .intx_in(intx_in),
        .link_state(link_state), .csr_addr(csr_addr), .csr_wr(csr_wr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_addr = a; csr_wdata = d; csr_wr = 1'b1;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    task automatic pulse(input logic [8:0] p);
        @(negedge clk);
        misc_src = p[4:0]; intx_in = p[8:5];
        @(negedge clk);
        misc_src = '0; intx_in = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(A_STAT, d); chk("R1 status", d, 0);
        rd(A_EN, d);   chk("R1 enable", d, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2 R3 R4 R8: every status pattern, paired enable
        for (int p = 0; p < 512; p++) begin
            logic [8:0] e;
            wr(A_STAT, 32'hFFFF_FFFF);
            pulse(p[8:0]);
            rd(A_STAT, d); chk("R2 R3 R4 status capture", d, p);
            e = 9'((p * 37 + 11) & 9'h1FF);
            wr(A_EN, {23'd0, e});
            chk("R8 irq combine", {31'd0, irq}, {31'd0, |(p[8:0] & e)});
        end

        // R2 single legacy line position
        wr(A_STAT, 32'h1FF);
        pulse(9'h040);
        rd(A_STAT, d); chk("R2 INTB at bit 6", d, 32'h40);

        // R5 write-one-to-clear
        pulse(9'h1FF);
        wr(A_STAT, 32'h0);          rd(A_STAT, d); chk("R5 zero write", d, 32'h1FF);
        wr(A_STAT, 32'hFFFF_FE00);  rd(A_STAT, d); chk("R5 upper bits", d, 32'h1FF);
        wr(A_STAT, 32'h0F0);        rd(A_STAT, d); chk("R5 partial clear", d, 32'h10F);

        // R7 enable sweep with fixed pending pattern 0x155
        wr(A_STAT, 32'h1FF);
        pulse(9'h155);
        for (int e = 0; e < 512; e++) begin
            wr(A_EN, 32'hFFFF_FE00 | e);
            rd(A_EN, d); chk("R7 enable readback", d, e);
            chk("R8 irq vs enable", {31'd0, irq}, {31'd0, |(9'h155 & e[8:0])});
        end
        rd(A_STAT, d); chk("R7 status untouched", d, 32'h155);

        // R6 level line held through a clear
        wr(A_STAT, 32'h1FF);
        @(negedge clk); intx_in = 4'b0100;
        wr(A_STAT, 32'h080);
        rd(A_STAT, d); chk("R6 level wins over clear", d, 32'h080);
        @(negedge clk); intx_in = '0;
        wr(A_STAT, 32'h080);
        rd(A_STAT, d); chk("R3 clear after drop", d, 32'h0);

        // R6 edge arriving with a clear
        @(negedge clk);
        misc_src = 5'b00001; csr_addr = A_STAT; csr_wdata = 32'h1; csr_wr = 1'b1;
        @(negedge clk); csr_wr = 1'b0;
        rd(A_STAT, d); chk("R6 edge wins over clear", d, 32'h1);
        // R4 held edge source does not re-set
        wr(A_STAT, 32'h1);
        repeat (3) @(negedge clk);
        rd(A_STAT, d); chk("R4 held source stays clear", d, 32'h0);
        misc_src = '0;
        @(negedge clk); misc_src = 5'b00001;
        @(negedge clk); misc_src = '0;
        rd(A_STAT, d); chk("R4 new edge sets", d, 32'h1);

        // R9 single-bit mask changes, R8 late enable
        wr(A_STAT, 32'h1FF);
        pulse(9'h1E0);
        wr(A_EN, 32'h1E0);
        rd(A_EN, d); wr(A_EN, d & ~32'h20);
        rd(A_EN, d); chk("R9 mask INTA only", d, 32'h1C0);
        chk("R9 irq from others", {31'd0, irq}, 1);
        wr(A_STAT, 32'h1C0);
        rd(A_STAT, d); chk("R9 INTA still pending", d, 32'h20);
        chk("R9 irq masked", {31'd0, irq}, 0);
        rd(A_EN, d); wr(A_EN, d | 32'h20);
        rd(A_EN, d); chk("R9 unmask INTA", d, 32'h1E0);
        chk("R8 late enable raises irq", {31'd0, irq}, 1);

        // R11 unmapped and link writes
        wr(16'h0000, 32'hFFFF_FFFF);
        wr(A_LINK, 32'hFFFF_FFFF);
        rd(A_STAT, d); chk("R11 status unchanged", d, 32'h20);
        rd(A_EN, d);   chk("R11 enable unchanged", d, 32'h1E0);
        rd(16'h0B10, d); chk("R11 unmapped read", d, 0);
        rd(16'h0B1D, d); chk("R11 near-miss read", d, 0);

        // R10 link sweep
        for (int s = 0; s < 64; s++) begin
            @(negedge clk); link_state = 6'(s);
            @(negedge clk);
            rd(A_LINK, d);
            chk("R10 link readback", d, {23'd0, (s == 32'h2D), 2'b00, 6'(s)});
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule